// File: doc/BRIEF.md
# Twelve-Pulse Memory Cycle Sequencer with Odd Parity

This block runs a storage access that never stops. Every access lasts twelve timing pulses. The sequencer latches an address and fetches the addressed word into a buffer. During a fixed window in the middle of the cycle it lets the processor see the buffer and overwrite it. It then restores the buffer to the same location. The current pulse number is driven out, so logic around the block can line its own work up with the schedule.

The storage is a behavioural array held inside the block. The lower part of the address space is a writable scratch region. The upper part is a read-only region whose contents come from a fixed formula. Scratch words reach the buffer one pulse earlier than read-only words.

Every stored word carries fifteen data bits and one parity bit, and the ones across all sixteen bits must total an odd number. Parity is generated on every restore and checked on every fetch. A failed check sets an alarm that stays set until a clear input is pulsed. A parameter picks one read-only location whose stored parity bit is deliberately wrong, so the check path can be exercised.

Top module: `mem_cycle_seq`

## Requirements
- R1: `tp_idx` counts 1,2,...,12 and then returns to 1, advancing once per clock. It reads 1 in reset and in the first clock after reset is released.
- R2: The address register loads `addr_in` only at the clock edge that ends pulse 1, and only when `addr_ld` is high. A load request in any other pulse is ignored, and that cycle accesses the previous address again.
- R3: Addresses below 32 are scratch. For these, the addressed word is shown on `g_data` from pulse 6 onward.
- R4: Addresses 32 to 63 are read-only. For these, `g_data` keeps its previous value during pulse 6. From pulse 7 it shows the read-only word, whose data is (a*677 + 4951) mod 32768 for address a.
- R5: `g_valid` is high exactly during pulses 7, 8, 9 and 10.
- R6: When `mod_we` is high in pulses 7 to 10, `mod_data` replaces the buffer and is shown on `g_data` from the next pulse. When `mod_we` is high in any other pulse, it has no effect on `g_data`.
- R7: At the edge that ends pulse 11, the buffer, including any modification, is restored to a scratch location. A later fetch of that address returns it. Scratch words read as 0 after reset.
- R8: Writes to read-only addresses are suppressed. A modified read-only word reads back with its formula value on the next fetch.
- R9: Parity is odd: bit 15 of each stored word makes the number of ones across bits 15..0 odd. Fetching a word with correct parity never sets `par_alarm`.
- R10: A fetch with bad parity sets `par_alarm` from the next pulse. The default bad-parity location is address 63. The alarm stays set until `alarm_clr` is seen at an edge. If a bad fetch and a clear happen at the same edge, the alarm is set.
- R11: During reset `g_data` is 0, `par_alarm` is 0 and the address register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pulse clock, one period per timing pulse |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 6 | Address to access |
| addr_ld | input | 1 | Request to load `addr_in`, taken only in pulse 1 |
| mod_we | input | 1 | Overwrite the buffer, taken only in pulses 7 to 10 |
| mod_data | input | 15 | Replacement data for the buffer |
| alarm_clr | input | 1 | Clear the sticky parity alarm |
| tp_idx | output | 4 | Current timing pulse, 1 to 12 |
| g_data | output | 15 | Buffer contents |
| g_valid | output | 1 | High during the processor access window |
| par_alarm | output | 1 | Sticky parity failure flag |

## Verification
Every output is registered, so a change made at the edge that ends pulse k shows up at the pulse k+1 sample. The bench samples on the falling edge, midway through each pulse. The cases that follow from this are:
- A scratch fetch is due at the pulse 6 sample.
- A read-only fetch and its alarm are due at the pulse 7 sample.
- A modification made in pulse k is due at pulse k+1.
- A restored word is first seen at pulse 6 of the next cycle that fetches that address.

At every sample the bench compares each output against a pulse-stepped model, so an early or late change fails at the exact pulse where it appears.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  // Pulse schedule: each value names the pulse whose closing edge performs the action.
  localparam int TP_ADDR   = 1;   // address capture
  localparam int TP_ERA_LD = 5;   // scratch fetch (visible during pulse 6)
  localparam int TP_FIX_LD = 6;   // read-only fetch (visible during pulse 7)
  localparam int TP_WIN_LO = 7;   // first pulse of the processor window
  localparam int TP_WIN_HI = 10;  // last pulse of the processor window
  localparam int TP_WB     = 11;  // restore to storage

  // Content formula of the read-only region.
  function automatic logic [31:0] fixed_data(input logic [31:0] a);
    return a * 32'd677 + 32'd4951;
  endfunction
endpackage

// File: rtl/mcs_rst_sync.sv
module mcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= 1'b1;
      ff2_q <= ff1_q;
    end
  end

  assign rst_sync_n = ff2_q;
endmodule

// File: rtl/mcs_pulse_ctr.sv
module mcs_pulse_ctr #(
  parameter int NPULSE = 12,
  localparam int TPW   = $clog2(NPULSE + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [TPW-1:0] tp
);
  logic [TPW-1:0] tp_q, tp_d;

  always_comb begin
    if (tp_q == TPW'(NPULSE)) tp_d = TPW'(1);
    else                      tp_d = tp_q + TPW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tp_q <= TPW'(1);
    else        tp_q <= tp_d;
  end

  assign tp = tp_q;

  // R1: pulse index never leaves 1..NPULSE
  assert_tp_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_q >= TPW'(1)) && (tp_q <= TPW'(NPULSE)));
  // R1: last pulse is followed by pulse 1
  assert_tp_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_q == TPW'(NPULSE)) |=> (tp_q == TPW'(1)));
endmodule

// File: rtl/mcs_parity.sv
module mcs_parity #(
  parameter int DW = 15
) (
  input  logic [DW-1:0] wdata,
  output logic          wpar,
  input  logic [DW:0]   rword,
  output logic          rd_bad
);
  // Odd parity: parity bit set when the data has an even number of ones.
  assign wpar   = ~^wdata;
  // Stored word is bad when its total count of ones is even.
  assign rd_bad = ~^rword;
endmodule

// File: rtl/mcs_store.sv
module mcs_store #(
  parameter int AW         = 6,
  parameter int DW         = 15,
  parameter int FIXED_BASE = 32,
  parameter int BAD_ADDR   = 63,
  localparam int WW        = DW + 1,
  localparam int EW        = $clog2(FIXED_BASE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rword,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wword
);
  localparam logic [WW-1:0] RST_WORD = {1'b1, {DW{1'b0}}};

  logic [WW-1:0] era [FIXED_BASE];
  logic [DW-1:0] rom_d;
  logic          rom_p;

  for (genvar i = 0; i < FIXED_BASE; i++) begin : g_word
    logic wen;
    assign wen = we && (waddr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   era[i] <= RST_WORD;
      else if (wen) era[i] <= wword;
    end
  end

  always_comb begin
    rom_d = DW'(mcs_pkg::fixed_data(32'(raddr)));
    rom_p = (~^rom_d) ^ (raddr == AW'(BAD_ADDR));
    if (raddr < AW'(FIXED_BASE)) rword = era[raddr[EW-1:0]];
    else                         rword = {rom_p, rom_d};
  end

  // R8: no write ever reaches the read-only region
  assert_fixed_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr < AW'(FIXED_BASE)));
  // R9: every written word carries odd parity
  assert_wr_odd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (($countones(wword) % 2) == 1));
endmodule

// File: rtl/mem_cycle_seq.sv
module mem_cycle_seq #(
  parameter int AW         = 6,
  parameter int DW         = 15,
  parameter int NPULSE     = 12,
  parameter int FIXED_BASE = 32,
  parameter int BAD_ADDR   = 63,
  localparam int TPW       = $clog2(NPULSE + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr_in,
  input  logic           addr_ld,
  input  logic           mod_we,
  input  logic [DW-1:0]  mod_data,
  input  logic           alarm_clr,
  output logic [TPW-1:0] tp_idx,
  output logic [DW-1:0]  g_data,
  output logic           g_valid,
  output logic           par_alarm
);
  import mcs_pkg::*;

  logic           rst_i;
  logic [TPW-1:0] tp;
  logic [AW-1:0]  s_q, s_d;
  logic [DW-1:0]  g_q, g_d;
  logic           alarm_q, alarm_d;
  logic           s_en, g_en;
  logic           at_addr, at_era, at_fix, in_win, at_wb, is_fixed;
  logic           fetch, st_we, wpar, rd_bad;
  logic [DW:0]    rword;

  mcs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i));

  mcs_pulse_ctr #(.NPULSE(NPULSE)) u_ctr (.clk(clk), .rst_n(rst_i), .tp(tp));

  mcs_store #(.AW(AW), .DW(DW), .FIXED_BASE(FIXED_BASE), .BAD_ADDR(BAD_ADDR)) u_store (
    .clk(clk), .rst_n(rst_i), .raddr(s_q), .rword(rword),
    .we(st_we), .waddr(s_q), .wword({wpar, g_q}));

  mcs_parity #(.DW(DW)) u_par (.wdata(g_q), .wpar(wpar), .rword(rword), .rd_bad(rd_bad));

  // Pulse decode
  always_comb begin
    is_fixed = (s_q >= AW'(FIXED_BASE));
    at_addr  = (tp == TPW'(TP_ADDR));
    at_era   = (tp == TPW'(TP_ERA_LD));
    at_fix   = (tp == TPW'(TP_FIX_LD));
    in_win   = (tp >= TPW'(TP_WIN_LO)) && (tp <= TPW'(TP_WIN_HI));
    at_wb    = (tp == TPW'(TP_WB));
    fetch    = (at_era && !is_fixed) || (at_fix && is_fixed);
    st_we    = at_wb && !is_fixed;
  end

  // Next state
  always_comb begin
    s_en = at_addr && addr_ld;
    s_d  = addr_in;
    g_en = fetch || (in_win && mod_we);
    g_d  = fetch ? rword[DW-1:0] : mod_data;
    if (fetch && rd_bad) alarm_d = 1'b1;
    else if (alarm_clr)  alarm_d = 1'b0;
    else                 alarm_d = alarm_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      s_q     <= '0;
      g_q     <= '0;
      alarm_q <= 1'b0;
    end else begin
      if (s_en) s_q <= s_d;
      if (g_en) g_q <= g_d;
      alarm_q <= alarm_d;
    end
  end

  assign tp_idx    = tp;
  assign g_data    = g_q;
  assign g_valid   = in_win;
  assign par_alarm = alarm_q;

  // R2: address register moves only at the end of pulse 1
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (tp != TPW'(TP_ADDR)) |=> $stable(s_q));
  // R6: buffer is frozen outside fetch edges and the window
  assert_g_hold_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (!fetch && !in_win) |=> $stable(g_q));
  // R6: a window write lands in the buffer
  assert_g_mod_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (in_win && mod_we) |=> (g_data == $past(mod_data)));
  // R10: bad fetch raises the alarm
  assert_bad_sets_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (fetch && rd_bad) |=> par_alarm);
  // R10: alarm holds until cleared
  assert_alarm_sticky_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (par_alarm && !alarm_clr) |=> par_alarm);
endmodule

// File: tb/tb_mem_cycle_seq.sv
module tb_mem_cycle_seq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr_in;
  logic        addr_ld, mod_we, alarm_clr;
  logic [14:0] mod_data;
  logic [3:0]  tp_idx;
  logic [14:0] g_data;
  logic        g_valid, par_alarm;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench model state
  logic [5:0]  exp_s;
  logic [14:0] exp_g;
  logic        exp_alarm;
  logic [14:0] mem_m [32];

  mem_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .addr_ld(addr_ld),
    .mod_we(mod_we), .mod_data(mod_data), .alarm_clr(alarm_clr),
    .tp_idx(tp_idx), .g_data(g_data), .g_valid(g_valid), .par_alarm(par_alarm));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [14:0] rom_f(input logic [5:0] a);
    int v;
    v = (int'(a) * 677 + 4951) % 32768;
    return v[14:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp_v, input string what);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp_v, $time);
    end
  endtask

  // One full memory cycle. ld_at/mod_at/clr_at name the pulse (1..12) in which the
  // strobe is driven; 0 means never.
  task automatic run_cycle(input logic [5:0] addr, input int ld_at, input int mod_at,
                           input logic [14:0] mval, input int clr_at, input string tag);
    for (int k = 1; k <= 12; k++) begin
      logic fetch;
      @(negedge clk);
      chk("R1", int'(tp_idx), k, "tp_idx");
      chk("R5", int'(g_valid), int'(k >= 7 && k <= 10), "g_valid");
      chk(tag, int'(g_data), int'(exp_g), "g_data");
      chk(exp_alarm ? "R10" : "R9", int'(par_alarm), int'(exp_alarm), "par_alarm");
      addr_in   = addr;
      addr_ld   = (k == ld_at);
      mod_we    = (k == mod_at);
      mod_data  = mval;
      alarm_clr = (k == clr_at);
      // model of the edge that closes pulse k
      fetch = (k == 5 && exp_s < 32) || (k == 6 && exp_s >= 32);
      if (fetch) exp_g = (exp_s < 32) ? mem_m[exp_s[4:0]] : rom_f(exp_s);
      else if (k >= 7 && k <= 10 && k == mod_at) exp_g = mval;
      if (fetch && exp_s == 6'd63) exp_alarm = 1'b1;
      else if (k == clr_at)        exp_alarm = 1'b0;
      if (k == 11 && exp_s < 32)   mem_m[exp_s[4:0]] = exp_g;
      if (k == 1 && ld_at == 1)    exp_s = addr;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; addr_in = '0; addr_ld = 0; mod_we = 0; mod_data = '0; alarm_clr = 0;
    exp_s = '0; exp_g = '0; exp_alarm = 1'b0;
    for (int i = 0; i < 32; i++) mem_m[i] = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", int'(g_data), 0, "g_data in reset");
    chk("R11", int'(par_alarm), 0, "par_alarm in reset");
    chk("R1", int'(tp_idx), 1, "tp_idx in reset");
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);

    // R11/R3: address 0 fetched with no load reads 0
    run_cycle(6'd0, 0, 0, 15'h0, 0, "R11");
    // R7: write scratch 5 in pulse 8, read it back
    run_cycle(6'd5, 1, 8, 15'h1234, 0, "R6");
    run_cycle(6'd5, 1, 0, 15'h0, 0, "R7");
    // R2: load requested in pulse 3 is ignored, address 5 reused
    run_cycle(6'd9, 3, 0, 15'h0, 0, "R2");
    // R3: scratch edge window (mod at pulse 7 and 10)
    run_cycle(6'd9, 1, 7, 15'h2AAA, 0, "R3");
    run_cycle(6'd9, 1, 10, 15'h5555, 0, "R6");
    run_cycle(6'd9, 1, 0, 15'h0, 0, "R7");
    // R6: strobes at pulses 6 and 11 are ignored
    run_cycle(6'd9, 1, 6, 15'h7777, 0, "R6");
    run_cycle(6'd9, 1, 11, 15'h0F0F, 0, "R6");
    run_cycle(6'd9, 1, 0, 15'h0, 0, "R7");
    // R4: read-only fetch timing; R8: modification not stored
    run_cycle(6'd40, 1, 9, 15'h7FFF, 0, "R4");
    run_cycle(6'd40, 1, 0, 15'h0, 0, "R8");
    run_cycle(6'd32, 1, 0, 15'h0, 0, "R4");
    // R10: bad parity word, sticky, clear, set wins over clear
    run_cycle(6'd63, 1, 0, 15'h0, 0, "R10");
    run_cycle(6'd1, 1, 0, 15'h0, 0, "R10");
    run_cycle(6'd1, 1, 0, 15'h0, 2, "R10");
    run_cycle(6'd63, 1, 0, 15'h0, 6, "R10");
    run_cycle(6'd2, 1, 0, 15'h0, 3, "R9");

    // Constrained random traffic
    for (int n = 0; n < 200; n++) begin
      logic [5:0] a;
      int la, ma, ca;
      a  = 6'($urandom_range(0, 63));
      la = ($urandom_range(0, 3) != 0) ? 1 : int'($urandom_range(2, 12));
      ma = int'($urandom_range(0, 12));
      ca = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 12)) : 0;
      run_cycle(a, la, ma, 15'($urandom), ca, "R6");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule